// File: doc/BRIEF.md
# External Interrupt Edge/Level Capture

This block watches four asynchronous interrupt pins and turns each into a latched, software-visible event flag with one interrupt output per channel. Every channel is configured on its own: a sensitivity bit picks level or edge detection, and a polarity bit picks active-high/rising or active-low/falling. The pins are brought into the clock domain by a two-flop synchroniser before any detection takes place.

Software reaches the block over a simple single-cycle bus with combinational read data. Word address 0 is the flag register (write one to clear), address 1 holds the sensitivity bits and address 2 the polarity bits. Bit i of each register belongs to channel i. A flag, once set, stays set until software clears it or the channel is reconfigured, so short pulses are not lost.

Top module: `ext_irq_capture`

## Requirements
- R1: After a synchronous reset all flags and interrupt outputs are 0, every channel is level sensitive (sensitivity register reads 0x0) and active-high (polarity register reads 0xF); the synchroniser and edge history reset to 0.
- R2: A pin change that is stable before clock edge k reaches the detector after edge k+1, so an event it causes sets the flag at edge k+2 and not earlier.
- R3: With sensitivity bit 0, a channel's flag is set in every cycle in which the synchronised pin equals its active level (1 when polarity bit is 1, 0 when it is 0), and stays set after the pin goes inactive.
- R4: With sensitivity bit 1, a channel's flag is set only on a synchronised transition 0 to 1 (polarity 1) or 1 to 0 (polarity 0); holding the pin steady sets nothing new.
- R5: Writing address 0 clears each flag whose write-data bit is 1; a 0 bit leaves that flag unchanged.
- R6: In edge mode, a detected edge in the same cycle as a clear of that flag wins, and the flag remains set.
- R7: In level mode a clear of a flag whose pin is still active has no effect; the flag stays set.
- R8: A write to address 1 or 2 that changes a channel's sensitivity or polarity bit clears that channel's flag at the next edge; channels whose bits do not change keep their flags.
- R9: Bits 31 to 4 of every register read as 0, and write-data bits 31 to 4 have no effect on any register.
- R10: With bus_sel high and bus_wr low, bus_rdata shows address 0 flags, address 1 sensitivity, address 2 polarity and address 3 zero in the same cycle; with bus_sel low bus_rdata is 0.
- R11: irq_o bit i equals channel i's flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Asynchronous interrupt pins, one per channel |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word address: 0 flags, 1 sensitivity, 2 polarity |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 4 | Per-channel interrupt request, equal to the flag |

## Verification
A wrong synchroniser depth or edge history shows as an interrupt output that rises one cycle early or late against the two-edge latency, or as an edge reported while a pin sits still. A wrong priority between set, clear and reconfiguration shows at irq_o on the very next edge after the bus write, and is visible again on the flag register read in the same cycle. A corrupted sensitivity or polarity register shows on its read-back at once and as flags appearing on the wrong transitions within three cycles of the next pin change.

// File: rtl/eirq_pkg.sv
// Shared register address decode for the external interrupt capture block.
// Assumes a word-addressed bus of two address bits.
package eirq_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_FLAG  = 2'd0,
        REG_SENSE = 2'd1,
        REG_POL   = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/eirq_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each pin is independent (no multi-bit coherency is needed).
module eirq_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    // Shift the pins through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_o = stage_q[LAST];

    generate
        if (STAGES >= 2) begin : g_chain_chk
            // R2
            sync_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sync_o == $past(stage_q[LAST-1]));
        end
    endgenerate

endmodule

// File: rtl/eirq_chan.sv
// One capture channel: edge history, level/edge detection and the sticky flag.
// Assumes sync_i is already in the clock domain; cfg_chg_i pulses for one
// cycle when software changes this channel's sensitivity or polarity.
module eirq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic edge_mode_i,
    input  logic pol_high_i,
    input  logic clr_i,
    input  logic cfg_chg_i,
    output logic flag_o
);

    logic prev_q;
    logic flag_q;
    logic active;
    logic prev_active;
    logic edge_hit;
    logic hit;

    // Remember the previous synchronised sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    // Translate the polarity setting into an active condition
    always_comb begin
        active      = pol_high_i ? sync_i : ~sync_i;
        prev_active = pol_high_i ? prev_q : ~prev_q;
        edge_hit    = active & ~prev_active;
        hit         = edge_mode_i ? edge_hit : active;
    end

    // Sticky flag: reconfigure clears, detection beats a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (cfg_chg_i) flag_q <= 1'b0;
        else if (hit)       flag_q <= 1'b1;
        else if (clr_i)     flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !hit && !cfg_chg_i |=> !flag_o);
    // R6
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode_i && edge_hit && clr_i && !cfg_chg_i |=> flag_o);
    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode_i && active && !cfg_chg_i |=> flag_o);
    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg_i |=> !flag_o);

endmodule

// File: rtl/eirq_regs.sv
// Register file: sensitivity and polarity storage, clear and reconfigure
// strobes, and the combinational read multiplexer.
// Assumes single-cycle bus accesses with no wait states.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic [NUM_CH-1:0]     flags_i,
    output logic [NUM_CH-1:0]     edge_mode_o,
    output logic [NUM_CH-1:0]     pol_high_o,
    output logic [NUM_CH-1:0]     clr_o,
    output logic [NUM_CH-1:0]     cfg_chg_o,
    output logic [DATA_W-1:0]     bus_rdata
);

    reg_sel_e            sel;
    logic                wr_en;
    logic [NUM_CH-1:0]   wr_bits;
    logic [NUM_CH-1:0]   sense_q;
    logic [NUM_CH-1:0]   pol_q;
    logic                unused_wdata_hi;

    assign sel             = reg_sel_e'(bus_addr);
    assign wr_en           = bus_sel & bus_wr;
    assign wr_bits         = bus_wdata[NUM_CH-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_CH];

    // Decode the clear and reconfigure strobes for this cycle
    always_comb begin
        clr_o     = '0;
        cfg_chg_o = '0;
        if (wr_en) begin
            case (sel)
                REG_FLAG:  clr_o     = wr_bits;
                REG_SENSE: cfg_chg_o = wr_bits ^ sense_q;
                REG_POL:   cfg_chg_o = wr_bits ^ pol_q;
                default:   ;
            endcase
        end
    end

    // Store the sensitivity and polarity settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            pol_q   <= '1;
        end else if (wr_en) begin
            if (sel == REG_SENSE) sense_q <= wr_bits;
            if (sel == REG_POL)   pol_q   <= wr_bits;
        end
    end

    // Zero-extended read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (sel)
                REG_FLAG:  bus_rdata[NUM_CH-1:0] = flags_i;
                REG_SENSE: bus_rdata[NUM_CH-1:0] = sense_q;
                REG_POL:   bus_rdata[NUM_CH-1:0] = pol_q;
                default:   ;
            endcase
        end
    end

    assign edge_mode_o = sense_q;
    assign pol_high_o  = pol_q;

    // R9
    sense_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sel == REG_SENSE |=> edge_mode_o == $past(bus_wdata[NUM_CH-1:0]));
    // R9
    pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sel == REG_POL |=> pol_high_o == $past(bus_wdata[NUM_CH-1:0]));

endmodule

// File: rtl/ext_irq_capture.sv
// Top of the external interrupt capture block: synchronises the pins,
// runs one detector per channel and exposes the registers.
// Assumes pins are asynchronous and the bus is synchronous to clk.
module ext_irq_capture
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     pin_i,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_CH-1:0]     irq_o
);

    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] edge_mode;
    logic [NUM_CH-1:0] pol_high;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] cfg_chg;
    logic [NUM_CH-1:0] flags;

    eirq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eirq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .flags_i     (flags),
        .edge_mode_o (edge_mode),
        .pol_high_o  (pol_high),
        .clr_o       (clr),
        .cfg_chg_o   (cfg_chg),
        .bus_rdata   (bus_rdata)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            eirq_chan chan_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .sync_i      (pin_sync[c]),
                .edge_mode_i (edge_mode[c]),
                .pol_high_i  (pol_high[c]),
                .clr_i       (clr[c]),
                .cfg_chg_i   (cfg_chg[c]),
                .flag_o      (flags[c])
            );
        end
    endgenerate

    assign irq_o = flags;

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_CH] == '0);
    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == '0);

endmodule

// File: tb/ext_irq_capture_tb_top.sv
`timescale 1ns/1ps
module ext_irq_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_sy1, m_s, m_sd, m_flag, m_sense, m_pol;
    logic [3:0] cur_pins;
    logic [31:0] last_rd;

    always #10 clk = ~clk;

    ext_irq_capture dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {28'b0, m_flag};
            2'd1:    return {28'b0, m_sense};
            2'd2:    return {28'b0, m_pol};
            default: return 32'b0;
        endcase
    endfunction

    // One bus/pin cycle, driven at the falling edge; model advanced in step
    task automatic step(input logic sel, input logic wr, input logic [1:0] a, input logic [31:0] wd);
        logic [3:0] act, pact, hit, clr, chg, nflag;
        pin_i = cur_pins; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        last_rd = bus_rdata;
        if (sel && !wr) check("R10", bus_rdata, exp_read(a));
        for (int i = 0; i < 4; i++) begin
            act[i]  = m_pol[i] ? m_s[i]  : ~m_s[i];
            pact[i] = m_pol[i] ? m_sd[i] : ~m_sd[i];
            hit[i]  = m_sense[i] ? (act[i] & ~pact[i]) : act[i];
        end
        clr = (sel && wr && a == 2'd0) ? wd[3:0] : 4'b0;
        chg = 4'b0;
        if (sel && wr && a == 2'd1) chg = wd[3:0] ^ m_sense;
        if (sel && wr && a == 2'd2) chg = wd[3:0] ^ m_pol;
        for (int i = 0; i < 4; i++)
            nflag[i] = chg[i] ? 1'b0 : hit[i] ? 1'b1 : clr[i] ? 1'b0 : m_flag[i];
        if (sel && wr && a == 2'd1) m_sense = wd[3:0];
        if (sel && wr && a == 2'd2) m_pol = wd[3:0];
        m_flag = nflag; m_sd = m_s; m_s = m_sy1; m_sy1 = cur_pins;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R11", {28'b0, irq_o}, {28'b0, m_flag});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d);
    endtask

    task automatic rd_expect(input string tag, input logic [1:0] a, input logic [31:0] e);
        step(1'b1, 1'b0, a, 32'h0);
        check(tag, last_rd, e);
    endtask

    task automatic irq_expect(input string tag, input logic [3:0] e);
        check(tag, {28'b0, irq_o}, {28'b0, e});
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R11: watchdog expired, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        m_sy1 = '0; m_s = '0; m_sd = '0; m_flag = '0; m_sense = '0; m_pol = '1;
        cur_pins = '0; last_rd = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        irq_expect("R1", 4'h0);
        rd_expect("R1", 2'd0, 32'h0);
        rd_expect("R1", 2'd1, 32'h0);
        rd_expect("R1", 2'd2, 32'hF);

        // R2 latency and R3 level detection
        cur_pins = 4'b0001;
        idle(2);
        irq_expect("R2", 4'h0);
        idle(1);
        irq_expect("R2", 4'h1);
        // R7 clear ignored while level still active
        wr(2'd0, 32'h1);
        irq_expect("R7", 4'h1);
        cur_pins = 4'b0000;
        idle(3);
        irq_expect("R3", 4'h1);
        wr(2'd0, 32'h1);
        irq_expect("R5", 4'h0);
        cur_pins = 4'b0010;
        idle(3);
        cur_pins = 4'b0000;
        idle(3);
        wr(2'd0, 32'h0);
        irq_expect("R5", 4'h2);
        wr(2'd0, 32'h2);
        irq_expect("R5", 4'h0);

        // R4 edge mode: ch0/ch2 rising, ch1/ch3 falling
        wr(2'd1, 32'hF);
        wr(2'd2, 32'h5);
        idle(3);
        cur_pins = 4'hF;
        idle(3);
        irq_expect("R4", 4'h5);
        idle(1);
        wr(2'd0, 32'hF);
        irq_expect("R4", 4'h0);
        cur_pins = 4'h0;
        idle(3);
        irq_expect("R4", 4'hA);
        wr(2'd0, 32'hF);
        irq_expect("R5", 4'h0);

        // R6 edge in the same cycle as its clear
        cur_pins = 4'b0001;
        idle(2);
        wr(2'd0, 32'hF);
        irq_expect("R6", 4'h1);
        idle(1);
        irq_expect("R6", 4'h1);
        wr(2'd0, 32'h1);
        irq_expect("R5", 4'h0);

        // R8 reconfiguration clears only the changed channel
        wr(2'd2, 32'hF);
        wr(2'd1, 32'h0);
        cur_pins = 4'hF;
        idle(3);
        irq_expect("R3", 4'hF);
        cur_pins = 4'h0;
        idle(3);
        irq_expect("R3", 4'hF);
        wr(2'd1, 32'h4);
        irq_expect("R8", 4'hB);

        // R9 reserved bits
        wr(2'd1, 32'hFFFF_FFF4);
        rd_expect("R9", 2'd1, 32'h4);
        wr(2'd0, 32'hFFFF_FFF0);
        irq_expect("R9", 4'hB);
        rd_expect("R9", 2'd0, 32'hB);
        rd_expect("R9", 2'd2, 32'hF);

        // R10 spare address and deselected bus
        rd_expect("R10", 2'd3, 32'h0);
        #1;
        check("R10", bus_rdata, 32'h0);

        // Random phase checked against the model (R3 R4 R5 R6 R7 R8)
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            for (int i = 0; i < 4; i++)
                if (r[i*3 +: 3] == 3'd0) cur_pins[i] = ~cur_pins[i];
            if (r[15:14] == 2'd0) begin
                logic [31:0] d;
                logic [1:0]  a;
                a = r[17:16];
                d = $urandom;
                if (r[18] && a == 2'd1) d[3:0] = m_sense;
                if (r[18] && a == 2'd2) d[3:0] = m_pol;
                step(1'b1, r[19], a, d);
            end else begin
                idle(1);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule